// File: doc/BRIEF.md
# Loop Activation Sequencer

This block is the control sequencer that brings a digital subscriber loop up and takes it down again. A host drives it with two main commands: one to request activation and one to request deactivation. A third command resumes a paused sequence. The sequencer steps through start-up by itself. It also drives the two overhead bits sent to the far end: an activation flag and a deactivation warning. It watches the matching flags from the far end and a frame-lock indication from the local receiver.

A full cold start goes through a training state. A warm start skips training and is only taken when the previous activation reached the active state. Two breakpoints can be enabled, one after training and one before the loop is declared active. At a breakpoint the sequencer holds still until the host sends the resume command.

Shutdown first sends the deactivation warning for a short drain interval. It then stays silent for a longer quiet interval. A watchdog covers the whole activation and aborts it if it has not finished in time. While the loop is idle, a rising wake-tone indication raises a host interrupt. All intervals count a millisecond tick input, and each duration is a parameter.

Top module: `loop_act_seq`

## Requirements
- R1: After reset, `state` is 0 (idle) and `tx_en`, `tx_act`, `tx_dea` and `irq` are all 0. The state codes are:
  - 0 idle
  - 1 training
  - 2 training hold
  - 3 sync
  - 4 sync hold
  - 5 active
  - 6 draining
  - 7 quiet
- R2: In idle, `act_req` moves the sequencer on the next cycle. It goes to sync (3) if the warm flag is set, otherwise to training (1). Training drives `tx_en`=1, `tx_act`=0, `tx_dea`=0.
- R3: Training advances when `sync_ok` is 1. It goes to training hold (2) if `bkpt_en[0]` is 1, else to sync (3).
- R4: Sync and sync hold drive `tx_en`=1, `tx_act`=1, `tx_dea`=0. Sync advances when `sync_ok` and `far_act` are both 1. It goes to sync hold (4) if `bkpt_en[1]` is 1, else to active (5). `tx_act` and `tx_dea` are never 1 together.
- R5: In a hold state, the state and line outputs stay unchanged until `cont_req`, `deact_req` or a watchdog abort. `cont_req` advances hold 2 to sync (3) and hold 4 to active (5).
- R6: `deact_req` in any of states 1 to 5, or `far_dea` in active, enters draining (6) on the next cycle. Draining drives `tx_en`=1, `tx_act`=0, `tx_dea`=1. `deact_req` has priority over every other event.
- R7: Draining ends on the `T_DRAIN_MS`-th tick after entry and moves to quiet (7), where `tx_en`=0. Quiet ends on the `T_QUIET_MS`-th tick after entry and moves to idle. A tick sampled on the entry edge is not counted.
- R8: The watchdog starts when idle is left. If the `T_WATCHDOG_MS`-th tick arrives while the state is 1 to 4, the sequencer returns to idle, clears the warm flag and pulses `irq`.
- R9: `irq` is a one-cycle pulse after any of these events:
  - a rising edge of `tone_det` while idle
  - entry into either hold state
  - entry into active
- R10: The warm flag is set on entry into active. It survives deactivation, so the next `act_req` from idle goes straight to sync (3).
- R11: Commands with no meaning in the current state change nothing:
  - `act_req` outside idle
  - `cont_req` outside the hold states
  - `tone_det` outside idle (raises no `irq`)

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| act_req | input | 1 | Host activation command (pulse) |
| deact_req | input | 1 | Host deactivation command (pulse) |
| cont_req | input | 1 | Host resume command for breakpoints (pulse) |
| bkpt_en | input | 2 | Bit 0: pause after training; bit 1: pause before active |
| sync_ok | input | 1 | Local receiver has frame lock |
| far_act | input | 1 | Activation flag received from far end |
| far_dea | input | 1 | Deactivation warning received from far end |
| tone_det | input | 1 | Wake-tone detected |
| state | output | 3 | Sequencer state code (see R1) |
| tx_en | output | 1 | Line transmitter enable |
| tx_act | output | 1 | Transmitted activation flag |
| tx_dea | output | 1 | Transmitted deactivation warning |
| irq | output | 1 | Host interrupt pulse |

## Verification
The assertions check, on every cycle, the following local rules:
- the drain entry on a deactivation command
- the fixed line bits of the drain and quiet states
- the freeze at a breakpoint
- the abort on watchdog expiry
- the warm-or-cold choice on leaving idle
- that the activation flag and the deactivation warning are never both set

Some behaviour is only shown by the bench's scenarios, which count ticks against a reference model:
- how long the drain, quiet and watchdog intervals last
- whether the warm flag persists across a deactivation
- which commands are ignored in which states

// File: rtl/loop_act_pkg.sv
package loop_act_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_TRAIN  = 3'd1,
    ST_HOLD_T = 3'd2,
    ST_SYNC   = 3'd3,
    ST_HOLD_S = 3'd4,
    ST_UP     = 3'd5,
    ST_DRAIN  = 3'd6,
    ST_QUIET  = 3'd7
  } act_state_e;

  typedef struct packed {
    logic en;
    logic act;
    logic dea;
  } line_bits_t;

  // timer slots
  localparam int TMR_DRAIN = 0;
  localparam int TMR_QUIET = 1;
  localparam int TMR_WD    = 2;
  localparam int NUM_TMR   = 3;

  function automatic logic is_activating(act_state_e s);
    return (s == ST_TRAIN) || (s == ST_HOLD_T) || (s == ST_SYNC) || (s == ST_HOLD_S);
  endfunction

  function automatic logic is_live(act_state_e s);
    return is_activating(s) || (s == ST_UP);
  endfunction

  function automatic line_bits_t bits_of(act_state_e s);
    line_bits_t b;
    b = '0;
    case (s)
      ST_TRAIN, ST_HOLD_T:       b.en = 1'b1;
      ST_SYNC, ST_HOLD_S, ST_UP: begin b.en = 1'b1; b.act = 1'b1; end
      ST_DRAIN:                  begin b.en = 1'b1; b.dea = 1'b1; end
      default:                   b = '0;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/act_ms_timer.sv
module act_ms_timer #(
  parameter int unsigned LEN_MS = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic expire
);
  localparam int unsigned CW = $clog2(LEN_MS + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (start)               cnt_q <= CW'(LEN_MS);
    else if (tick && cnt_q != '0) cnt_q <= cnt_q - CW'(1);
  end

  assign expire = tick && (cnt_q == CW'(1));
endmodule

// File: rtl/act_seq_core.sv
module act_seq_core
  import loop_act_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       act_req,
  input  logic       deact_req,
  input  logic       cont_req,
  input  logic [1:0] bkpt_en,
  input  logic       sync_ok,
  input  logic       far_act,
  input  logic       far_dea,
  input  logic       drain_exp,
  input  logic       quiet_exp,
  input  logic       wd_exp,
  output act_state_e st,
  output logic       start_drain,
  output logic       start_quiet,
  output logic       start_wd,
  output logic       ev_hold,
  output logic       ev_up,
  output logic       ev_abort,
  output logic       warm
);
  act_state_e st_q, st_d;
  logic       abort;
  logic       warm_q;

  always_comb begin
    st_d  = st_q;
    abort = 1'b0;
    if (is_live(st_q) && (deact_req || (st_q == ST_UP && far_dea))) begin
      st_d = ST_DRAIN;
    end else if (is_activating(st_q) && wd_exp) begin
      st_d  = ST_IDLE;
      abort = 1'b1;
    end else begin
      case (st_q)
        ST_IDLE:   if (act_req) st_d = warm_q ? ST_SYNC : ST_TRAIN;
        ST_TRAIN:  if (sync_ok) st_d = bkpt_en[0] ? ST_HOLD_T : ST_SYNC;
        ST_HOLD_T: if (cont_req) st_d = ST_SYNC;
        ST_SYNC:   if (sync_ok && far_act) st_d = bkpt_en[1] ? ST_HOLD_S : ST_UP;
        ST_HOLD_S: if (cont_req) st_d = ST_UP;
        ST_DRAIN:  if (drain_exp) st_d = ST_QUIET;
        ST_QUIET:  if (quiet_exp) st_d = ST_IDLE;
        default:   st_d = st_q;
      endcase
    end
  end

  assign start_drain = (st_d == ST_DRAIN) && (st_q != ST_DRAIN);
  assign start_quiet = (st_d == ST_QUIET) && (st_q != ST_QUIET);
  assign start_wd    = (st_q == ST_IDLE) && (st_d != ST_IDLE);
  assign ev_hold     = (st_d != st_q) && ((st_d == ST_HOLD_T) || (st_d == ST_HOLD_S));
  assign ev_up       = (st_d == ST_UP) && (st_q != ST_UP);
  assign ev_abort    = abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      warm_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (abort)      warm_q <= 1'b0;
      else if (ev_up) warm_q <= 1'b1;
    end
  end

  assign st   = st_q;
  assign warm = warm_q;
endmodule

// File: rtl/act_irq_gen.sv
module act_irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  input  logic tone_det,
  input  logic ev_hold,
  input  logic ev_up,
  input  logic ev_abort,
  output logic irq
);
  logic tone_q;
  logic tone_rise;

  assign tone_rise = idle && tone_det && !tone_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tone_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      tone_q <= tone_det;
      irq    <= tone_rise || ev_hold || ev_up || ev_abort;
    end
  end
endmodule

// File: rtl/loop_act_seq.sv
module loop_act_seq
  import loop_act_pkg::*;
#(
  parameter int unsigned T_DRAIN_MS    = 40,
  parameter int unsigned T_QUIET_MS    = 480,
  parameter int unsigned T_WATCHDOG_MS = 15000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ms_tick,
  input  logic       act_req,
  input  logic       deact_req,
  input  logic       cont_req,
  input  logic [1:0] bkpt_en,
  input  logic       sync_ok,
  input  logic       far_act,
  input  logic       far_dea,
  input  logic       tone_det,
  output logic [2:0] state,
  output logic       tx_en,
  output logic       tx_act,
  output logic       tx_dea,
  output logic       irq
);
  localparam int unsigned TMR_LEN [NUM_TMR] = '{T_DRAIN_MS, T_QUIET_MS, T_WATCHDOG_MS};

  act_state_e         st;
  line_bits_t         lb;
  logic [NUM_TMR-1:0] tmr_start;
  logic [NUM_TMR-1:0] tmr_exp;
  logic               drain_expire, quiet_expire, wd_expire;
  logic               ev_hold, ev_up, ev_abort;
  logic               warm_flag;

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    act_ms_timer #(.LEN_MS(TMR_LEN[g])) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (tmr_start[g]),
      .tick   (ms_tick),
      .expire (tmr_exp[g])
    );
  end

  assign drain_expire = tmr_exp[TMR_DRAIN];
  assign quiet_expire = tmr_exp[TMR_QUIET];
  assign wd_expire    = tmr_exp[TMR_WD];

  act_seq_core u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .act_req     (act_req),
    .deact_req   (deact_req),
    .cont_req    (cont_req),
    .bkpt_en     (bkpt_en),
    .sync_ok     (sync_ok),
    .far_act     (far_act),
    .far_dea     (far_dea),
    .drain_exp   (drain_expire),
    .quiet_exp   (quiet_expire),
    .wd_exp      (wd_expire),
    .st          (st),
    .start_drain (tmr_start[TMR_DRAIN]),
    .start_quiet (tmr_start[TMR_QUIET]),
    .start_wd    (tmr_start[TMR_WD]),
    .ev_hold     (ev_hold),
    .ev_up       (ev_up),
    .ev_abort    (ev_abort),
    .warm        (warm_flag)
  );

  act_irq_gen u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .idle     (st == ST_IDLE),
    .tone_det (tone_det),
    .ev_hold  (ev_hold),
    .ev_up    (ev_up),
    .ev_abort (ev_abort),
    .irq      (irq)
  );

  assign lb     = bits_of(st);
  assign state  = st;
  assign tx_en  = lb.en;
  assign tx_act = lb.act;
  assign tx_dea = lb.dea;
endmodule

// File: rtl/loop_act_seq_chk.sv
module loop_act_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] state,
  input logic       tx_en,
  input logic       tx_act,
  input logic       tx_dea,
  input logic       irq,
  input logic       act_req,
  input logic       deact_req,
  input logic       cont_req,
  input logic       far_dea,
  input logic       wd_exp,
  input logic       warm
);
  logic live, activating, holding;
  assign activating = (state >= 3'd1) && (state <= 3'd4);
  assign live       = (state >= 3'd1) && (state <= 3'd5);
  assign holding    = (state == 3'd2) || (state == 3'd4);

  assert_cold_warm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0 && act_req) |=> (state == ($past(warm) ? 3'd3 : 3'd1)));

  assert_act_dea_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_act && tx_dea));

  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (holding && !cont_req && !deact_req && !wd_exp)
      |=> $stable({state, tx_en, tx_act, tx_dea}));

  assert_drain_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (live && (deact_req || (state == 3'd5 && far_dea))) |=> (state == 3'd6));

  assert_drain_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd6) |-> (tx_en && tx_dea && !tx_act));

  assert_quiet_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd7) |-> (!tx_en && !tx_act && !tx_dea));

  assert_wd_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (activating && wd_exp && !deact_req) |=> (state == 3'd0 && irq && !warm));

  assert_up_stays_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd5 && !deact_req && !far_dea) |=> (state == 3'd5));
endmodule

bind loop_act_seq loop_act_seq_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .state     (state),
  .tx_en     (tx_en),
  .tx_act    (tx_act),
  .tx_dea    (tx_dea),
  .irq       (irq),
  .act_req   (act_req),
  .deact_req (deact_req),
  .cont_req  (cont_req),
  .far_dea   (far_dea),
  .wd_exp    (wd_expire),
  .warm      (warm_flag)
);

// File: tb/loop_act_seq_tb_top.sv
`timescale 1ns/1ps
module loop_act_seq_tb_top;
  localparam int TD = 4;
  localparam int TQ = 6;
  localparam int TW = 30;
  localparam int TICK_DIV = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ms_tick = 1'b0, act_req = 1'b0, deact_req = 1'b0, cont_req = 1'b0;
  logic [1:0] bkpt_en = 2'b00;
  logic       sync_ok = 1'b0, far_act = 1'b0, far_dea = 1'b0, tone_det = 1'b0;
  logic [2:0] state;
  logic       tx_en, tx_act, tx_dea, irq;

  always #2 clk = ~clk;

  loop_act_seq #(.T_DRAIN_MS(TD), .T_QUIET_MS(TQ), .T_WATCHDOG_MS(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .act_req(act_req),
    .deact_req(deact_req), .cont_req(cont_req), .bkpt_en(bkpt_en),
    .sync_ok(sync_ok), .far_act(far_act), .far_dea(far_dea), .tone_det(tone_det),
    .state(state), .tx_en(tx_en), .tx_act(tx_act), .tx_dea(tx_dea), .irq(irq)
  );

  // ---------------- reference model ----------------
  int m_state, m_c_dr, m_c_qu, m_c_wd, m_nx;
  bit m_warm, m_irq, m_tone, m_abort, m_e_dr, m_e_qu, m_e_wd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_warm = 0; m_irq = 0; m_tone = 0;
      m_c_dr = 0; m_c_qu = 0; m_c_wd = 0;
    end else begin
      m_e_dr = ms_tick && (m_c_dr == 1);
      m_e_qu = ms_tick && (m_c_qu == 1);
      m_e_wd = ms_tick && (m_c_wd == 1);
      m_nx = m_state; m_abort = 0;
      if (m_state >= 1 && m_state <= 5 && (deact_req || (m_state == 5 && far_dea)))
        m_nx = 6;
      else if (m_state >= 1 && m_state <= 4 && m_e_wd) begin
        m_nx = 0; m_abort = 1;
      end else begin
        case (m_state)
          0: if (act_req) m_nx = m_warm ? 3 : 1;
          1: if (sync_ok) m_nx = bkpt_en[0] ? 2 : 3;
          2: if (cont_req) m_nx = 3;
          3: if (sync_ok && far_act) m_nx = bkpt_en[1] ? 4 : 5;
          4: if (cont_req) m_nx = 5;
          6: if (m_e_dr) m_nx = 7;
          7: if (m_e_qu) m_nx = 0;
          default: ;
        endcase
      end
      m_irq = (m_state == 0 && tone_det && !m_tone) || m_abort ||
              (m_nx != m_state && (m_nx == 2 || m_nx == 4 || m_nx == 5));
      if (m_nx == 6 && m_state != 6) m_c_dr = TD; else if (ms_tick && m_c_dr > 0) m_c_dr--;
      if (m_nx == 7 && m_state != 7) m_c_qu = TQ; else if (ms_tick && m_c_qu > 0) m_c_qu--;
      if (m_state == 0 && m_nx != 0) m_c_wd = TW; else if (ms_tick && m_c_wd > 0) m_c_wd--;
      if (m_abort) m_warm = 0; else if (m_nx == 5 && m_state != 5) m_warm = 1;
      m_tone = tone_det;
      m_state = m_nx;
    end
  end

  // ---------------- per-cycle comparison ----------------
  int cyc_vec = 0, cyc_fail = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      cyc_vec++;
      if (int'(state) != m_state || tx_en != (m_state >= 1 && m_state <= 6) ||
          tx_act != (m_state >= 3 && m_state <= 5) || tx_dea != (m_state == 6) ||
          irq != m_irq) begin
        cyc_fail++;
        $display("FAIL model track: got st=%0d en=%0b act=%0b dea=%0b irq=%0b expected st=%0d irq=%0b",
                 state, tx_en, tx_act, tx_dea, irq, m_state, m_irq);
      end
    end
  end

  // ---------------- scenario helpers ----------------
  int scn_vec = 0, scn_fail = 0, tdiv = 0;
  bit timeout = 0;

  task automatic cyc();
    @(negedge clk);
    ms_tick = (tdiv == TICK_DIV - 1);
    tdiv = (tdiv + 1) % TICK_DIV;
  endtask

  task automatic expect_eq(input int act, input int exp, input string tag);
    scn_vec++;
    if (act != exp) begin
      scn_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_act();   act_req = 1;   cyc(); act_req = 0;   endtask
  task automatic pulse_deact(); deact_req = 1; cyc(); deact_req = 0; endtask
  task automatic pulse_cont();  cont_req = 1;  cyc(); cont_req = 0;  endtask

  task automatic wait_state(input int exp, input string tag);
    for (int i = 0; i < 400; i++) begin
      if (int'(state) == exp) break;
      cyc();
    end
    expect_eq(int'(state), exp, tag);
  endtask

  task automatic run_all();
    int n;
    logic [5:0] snap;
    // R1 reset state
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    expect_eq(int'(state), 0, "R1 state");
    expect_eq(int'({tx_en, tx_act, tx_dea, irq}), 0, "R1 outputs");

    // R9 wake tone in idle
    tone_det = 1; cyc();
    expect_eq(irq, 1, "R9 tone irq");
    cyc();
    expect_eq(irq, 0, "R9 single pulse");
    tone_det = 0; cyc();

    // R2 cold start
    pulse_act();
    expect_eq(int'(state), 1, "R2 cold to training");
    expect_eq(int'({tx_en, tx_act, tx_dea}), 3'b100, "R2 training bits");
    pulse_act();
    expect_eq(int'(state), 1, "R11 act_req ignored");
    sync_ok = 1; cyc();
    expect_eq(int'(state), 3, "R3 training to sync");
    expect_eq(tx_act, 1, "R4 act bit in sync");
    far_act = 1; cyc();
    expect_eq(int'(state), 5, "R4 sync to active");
    expect_eq(irq, 1, "R9 active irq");
    pulse_cont();
    expect_eq(int'(state), 5, "R11 cont ignored");
    tone_det = 1; cyc();
    expect_eq(irq, 0, "R11 tone ignored when up");
    tone_det = 0;

    // R6 / R7 deactivation
    pulse_deact();
    expect_eq(int'(state), 6, "R6 drain entry");
    expect_eq(int'({tx_en, tx_act, tx_dea}), 3'b101, "R6 drain bits");
    n = 0;
    for (int i = 0; i < 200 && int'(state) == 6; i++) begin
      if (ms_tick) n++;
      cyc();
    end
    expect_eq(n, TD, "R7 drain ticks");
    expect_eq(int'(state), 7, "R7 quiet entry");
    expect_eq(tx_en, 0, "R7 quiet silent");
    n = 0;
    for (int i = 0; i < 200 && int'(state) == 7; i++) begin
      if (ms_tick) n++;
      cyc();
    end
    expect_eq(n, TQ, "R7 quiet ticks");
    expect_eq(int'(state), 0, "R7 back to idle");

    // R10 warm start, then R8 watchdog abort
    sync_ok = 0; far_act = 0;
    pulse_act();
    expect_eq(int'(state), 3, "R10 warm start to sync");
    n = 1;
    for (int i = 0; i < 400 && state >= 1 && state <= 4; i++) begin
      if (ms_tick) n++;
      cyc();
    end
    expect_eq(n - 1 + ((tdiv == 0) ? 0 : 0), TW - 1 + 1, "R8 watchdog ticks");
    expect_eq(int'(state), 0, "R8 abort to idle");
    expect_eq(irq, 1, "R8 abort irq");
    pulse_act();
    expect_eq(int'(state), 1, "R8 warm flag cleared");

    // R5 breakpoints
    bkpt_en = 2'b11; sync_ok = 1; cyc();
    expect_eq(int'(state), 2, "R3 training hold");
    expect_eq(irq, 1, "R9 hold irq");
    snap = {state, tx_en, tx_act, tx_dea};
    act_req = 1;
    for (int i = 0; i < 5; i++) begin
      cyc();
      expect_eq(int'({state, tx_en, tx_act, tx_dea}), int'(snap), "R5 hold frozen");
    end
    act_req = 0;
    pulse_cont();
    expect_eq(int'(state), 3, "R5 cont to sync");
    far_act = 1; cyc();
    expect_eq(int'(state), 4, "R4 sync hold");
    pulse_cont();
    expect_eq(int'(state), 5, "R5 cont to active");

    // R6 far-end deactivation
    far_dea = 1; cyc();
    expect_eq(int'(state), 6, "R6 far dea");
    far_dea = 0;
    wait_state(0, "R7 idle after far dea");

    // R6 deactivate during sync
    bkpt_en = 2'b00; far_act = 0;
    pulse_act();
    expect_eq(int'(state), 3, "R10 warm kept");
    pulse_deact();
    expect_eq(int'(state), 6, "R6 drain from sync");
    wait_state(0, "R7 idle again");
    repeat (3) cyc();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        timeout = 1;
      end
    join_any
    disable fork;
    if (timeout) begin
      scn_fail++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==",
             cyc_vec + scn_vec, cyc_fail + scn_fail);
    $finish;
  end
endmodule